// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block gathers the data bytes of one serial write frame into a small staging buffer that spans a single page of the storage array. The frame opens with a starting address; each received byte lands at the current page offset, and the offset then advances. Only the low offset bits move, so the pointer wraps inside the page and later bytes replace earlier ones. The page number itself never changes during a frame.

Nothing reaches the array while bytes arrive. When chip select rises on a byte boundary, the protection controller must also grant the write, and at least one byte must be staged. If all three hold, the block enters a busy interval that lasts a parameterised number of clocks. During that interval it replays the staged bytes to the array, one per clock, and ignores all other traffic. At the end it drops busy and pulses a completion strobe that the control logic uses to clear its write-enable latch. If chip select rises partway through a byte, or the write is not granted, the frame is dropped.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy`, `arr_we` and `wr_done` are all 0.
- R2: A byte received in a frame is staged at the low 4 bits of the pointer. The pointer starts at `start_addr[3:0]` and increments after each byte. Array writes carry `start_addr[8:4]` unchanged in `arr_addr[8:4]`, with the staged offset in `arr_addr[3:0]`.
- R3: When the pointer passes offset 15 it returns to offset 0. A later byte at an offset replaces the earlier one, and only the last value is written.
- R4: No array write and no busy occur while a frame is being filled. The array is untouched until a qualifying `cs_rise`.
- R5: A `cs_rise` while `bit_pending` is 1 discards the frame. No busy interval and no array write follow.
- R6: A `cs_rise` while `accept` is 0 discards the frame. No busy interval and no array write follow.
- R7: On commit, only offsets loaded in the frame are written. The writes come one per clock in ascending offset order, and all of them fall within the busy interval.
- R8: `busy` rises the clock after a qualifying `cs_rise` and stays high for exactly `TWC_CYCLES` clocks.
- R9: `wr_done` is a single-clock pulse in the first clock after `busy` falls.
- R10: While `busy` is 1, `frame_start`, `byte_valid` and `cs_rise` are ignored. No second cycle and no extra writes result.
- R11: A `cs_rise` in a frame with no bytes staged starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Opens a write frame at `start_addr` |
| start_addr | input | 9 | Starting array address of the frame |
| byte_valid | input | 1 | A complete data byte is on `byte_data` |
| byte_data | input | 8 | Received data byte |
| bit_pending | input | 1 | A partial byte is in the deserialiser |
| cs_rise | input | 1 | Chip select rising-edge event |
| accept | input | 1 | Write granted by the protection controller |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 9 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| wr_done | output | 1 | One-clock pulse at end of the write cycle |

## Verification
The hardest situation to reach is traffic that arrives while the busy interval is still running. A fresh frame start, bytes and a granted chip-select rise must all leave no trace. The bench commits a one-byte frame, then drives a full new frame inside the busy window. Afterwards it confirms that the write stream held only the original byte and that no second busy interval began. Pointer wrap is reached by sending eighteen bytes from offset 14, so the final two bytes overwrite the first two.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    PWB_IDLE = 1'b0,
    PWB_FILL = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
  parameter int ADDR_W = 9,
  parameter int OFF_W  = 4,
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              inc,
  output logic [BASE_W-1:0] base,
  output logic [OFF_W-1:0]  off
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      off  <= '0;
    end else if (load) begin
      base <= start_addr[ADDR_W-1:OFF_W];
      off  <= start_addr[OFF_W-1:0];
    end else if (inc) begin
      off <= off + 1'b1;
    end
  end

  // page number never moves while bytes are counted
  assert_base_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> $stable(base));
  // offset wraps inside the page
  assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && (off == {OFF_W{1'b1}})) |=> (off == '0));
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  we,
  input  logic [OFF_W-1:0]      waddr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  re,
  input  logic [OFF_W-1:0]      raddr,
  output logic [DATA_W-1:0]     rdata,
  output logic [PAGE_BYTES-1:0] loaded
);
  logic [DATA_W-1:0] mem [PAGE_BYTES];

  // data storage: single write port, registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // per-slot occupancy flags
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear)                 loaded[g] <= 1'b0;
      else if (we && (waddr == OFF_W'(g))) loaded[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int PAGE_BYTES = 16,
  parameter int TWC_CYCLES = 625000,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int TMR_W = $clog2(TWC_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             scan_en,
  output logic [OFF_W-1:0] scan_idx
);
  logic [TMR_W-1:0] timer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      timer_q <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      timer_q <= TMR_W'(TWC_CYCLES);
    end else if (busy) begin
      timer_q <= timer_q - TMR_W'(1);
      if (timer_q == TMR_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_en  <= 1'b0;
      scan_idx <= '0;
    end else if (start && !busy) begin
      scan_en  <= 1'b1;
      scan_idx <= '0;
    end else if (scan_en) begin
      scan_idx <= scan_idx + 1'b1;
      if (scan_idx == OFF_W'(PAGE_BYTES - 1)) scan_en <= 1'b0;
    end
  end

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int TWC_CYCLES = 625000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              bit_pending,
  input  logic              cs_rise,
  input  logic              accept,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic              wr_done
);
  import pwb_pkg::*;

  pwb_state_e state_q;
  logic [BASE_W-1:0]     base;
  logic [OFF_W-1:0]      off;
  logic [PAGE_BYTES-1:0] loaded;
  logic                  scan_en;
  logic [OFF_W-1:0]      scan_idx;
  logic                  load, wr_byte, commit_go, discard;

  // frame control: nothing is accepted while the write cycle runs
  always_comb begin
    load      = frame_start && !busy;
    wr_byte   = byte_valid && (state_q == PWB_FILL) && !load && !busy;
    commit_go = cs_rise && (state_q == PWB_FILL) && !load && !busy &&
                !bit_pending && accept && (|loaded);
    discard   = cs_rise && (state_q == PWB_FILL) && !load && !commit_go;
  end

  always_ff @(posedge clk) begin
    if (rst)                     state_q <= PWB_IDLE;
    else if (load)               state_q <= PWB_FILL;
    else if (commit_go || discard) state_q <= PWB_IDLE;
  end

  pwb_addr_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
    .inc(wr_byte), .base(base), .off(off)
  );

  pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .clear(load), .we(wr_byte), .waddr(off),
    .wdata(byte_data), .re(scan_en), .raddr(scan_idx),
    .rdata(arr_wdata), .loaded(loaded)
  );

  pwb_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .TWC_CYCLES(TWC_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(commit_go), .busy(busy), .done(wr_done),
    .scan_en(scan_en), .scan_idx(scan_idx)
  );

  // write strobe aligned with the registered buffer read
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we   <= 1'b0;
      arr_addr <= '0;
    end else begin
      arr_we   <= scan_en && loaded[scan_idx];
      arr_addr <= {base, scan_idx};
    end
  end

  assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);
  assert_order_up_R7: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |-> (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));
  assert_no_fill_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (state_q == PWB_IDLE));
  assert_no_cycle_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && cs_rise && bit_pending) |=> !busy);
  assert_no_cycle_denied_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && cs_rise && !accept) |=> !busy);
endmodule

// File: tb/pwb_page_writer_tb.sv
module pwb_page_writer_tb_top;
  localparam int TWC = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic [8:0] start_addr = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       bit_pending = 1'b0;
  logic       cs_rise = 1'b0;
  logic       accept = 1'b1;
  logic       arr_we, busy, wr_done;
  logic [8:0] arr_addr;
  logic [7:0] arr_wdata;

  int total = 0;
  int bad = 0;
  int n_writes = 0;
  int busy_len = 0;
  logic prev_busy = 1'b0;
  logic [16:0] exp_q[$];

  logic [4:0]  mbase;
  logic [3:0]  moff;
  logic [7:0]  mbuf [16];
  logic [15:0] mmask;

  always #4 clk = ~clk;

  pwb_page_writer #(.TWC_CYCLES(TWC)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .bit_pending(bit_pending),
    .cs_rise(cs_rise), .accept(accept), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .busy(busy), .wr_done(wr_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare, busy length and done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (arr_we) begin
        n_writes++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected array write", {arr_addr, arr_wdata}, 0);
        end else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk({arr_addr, arr_wdata} == e, "R7 R2 R3 write addr/data",
              {arr_addr, arr_wdata}, e);
        end
      end
      if (busy) busy_len++;
      if (prev_busy && !busy) begin
        chk(busy_len == TWC, "R8 busy length", busy_len, TWC);
        chk(wr_done == 1'b1, "R9 done at busy fall", wr_done, 1);
        busy_len = 0;
      end else if (wr_done) begin
        chk(1'b0, "R9 stray done pulse", 1, 0);
      end
      prev_busy = busy;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic start_frame(input logic [8:0] a);
    start_addr  = a;
    frame_start = 1'b1;
    mbase = a[8:4];
    moff  = a[3:0];
    mmask = '0;
    step();
    frame_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit model);
    byte_data  = d;
    byte_valid = 1'b1;
    if (model) begin
      mbuf[moff]  = d;
      mmask[moff] = 1'b1;
      moff        = moff + 4'd1;
    end
    step();
    byte_valid = 1'b0;
  endtask

  task automatic end_frame(input bit pend, input bit acc, input bit model);
    bit_pending = pend;
    accept      = acc;
    cs_rise     = 1'b1;
    if (model && !pend && acc && (mmask != 0))
      for (int i = 0; i < 16; i++)
        if (mmask[i]) exp_q.push_back({mbase, 4'(i), mbuf[i]});
    step();
    cs_rise     = 1'b0;
    bit_pending = 1'b0;
    accept      = 1'b1;
  endtask

  task automatic wait_cycle_end();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all staged bytes written", exp_q.size(), 0);
  endtask

  task automatic expect_quiet(input string req);
    int w0;
    w0 = n_writes;
    repeat (TWC + 5) begin
      @(negedge clk);
      if (busy) begin
        chk(1'b0, req, 1, 0);
        break;
      end
    end
    chk(n_writes == w0 && !busy, req, n_writes - w0, 0);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) step();
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(arr_we == 0, "R1 arr_we after reset", arr_we, 0);
    chk(wr_done == 0, "R1 wr_done after reset", wr_done, 0);

    // R2/R4: small frame mid-page
    start_frame(9'h123);
    send_byte(8'hA1, 1);
    send_byte(8'hB2, 1);
    send_byte(8'hC3, 1);
    repeat (3) step();
    @(negedge clk);
    chk(arr_we == 0 && busy == 0, "R4 array idle while filling", {busy, arr_we}, 0);
    end_frame(0, 1, 1);
    wait_cycle_end();

    // R3: eighteen bytes from offset 14, wraps and overwrites
    start_frame(9'h07E);
    for (int i = 0; i < 18; i++) send_byte(8'h10 + 8'(i), 1);
    end_frame(0, 1, 1);
    wait_cycle_end();

    // R5: partial byte at chip select rise
    start_frame(9'h040);
    send_byte(8'h55, 1);
    send_byte(8'h66, 1);
    end_frame(1, 1, 1);
    expect_quiet("R5 partial byte discards frame");

    // R6: write not granted
    start_frame(9'h0A0);
    send_byte(8'h77, 1);
    end_frame(0, 0, 1);
    expect_quiet("R6 denied write discards frame");

    // R11: empty frame
    start_frame(9'h0B0);
    end_frame(0, 1, 1);
    expect_quiet("R11 empty frame starts no cycle");

    // R10: full frame driven during the busy interval
    start_frame(9'h150);
    send_byte(8'h5A, 1);
    end_frame(0, 1, 1);
    step();
    start_frame(9'h000);
    send_byte(8'hEE, 0);
    send_byte(8'hEF, 0);
    end_frame(0, 1, 0);
    wait_cycle_end();
    expect_quiet("R10 traffic during busy ignored");

    // R10/R4: bytes and select rise with no open frame
    send_byte(8'h99, 0);
    end_frame(0, 1, 0);
    expect_quiet("R10 bytes outside a frame ignored");

    // R7: sixteen bytes from offset 8, written back in ascending offset order
    start_frame(9'h1F8);
    for (int i = 0; i < 16; i++) send_byte(8'hC0 ^ 8'(i * 7), 1);
    end_frame(0, 1, 1);
    wait_cycle_end();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule